// File: doc/BRIEF.md
# Group Synchronous Start Controller

This block lets software launch several PWM channels in the same clock cycle. Each group slot holds three things. The first is a membership mask with one bit per channel. The second is a flag that asks for counter resets. The third is a self-clearing launch bit. When software writes 1 to a group's launch bit, the block raises a one-cycle "apply settings" pulse on every member channel. If the group's reset flag is set, it also raises a one-cycle "clear counter" pulse on those channels. The channel generators use these pulses to take their staged settings and, when asked, to restart their period counters together, so the waveforms start phase-aligned.

Access is through a plain register strobe with word addressing. A write is accepted on the clock edge where the write enable is high. Read data is combinational from the address, so there is no handshake and no back-pressure. The pulse outputs are control signals, not a data stream: they carry no valid/ready and cannot be stalled. Group slots repeat every 0x10 bytes from address 0x000. The map reserves room for 16 slots, and the number actually built is a parameter. When several groups contribute to one channel, the block ORs their pulses together, so a channel never sees more than one pulse of each kind per cycle.

Top module: `grp_sync_start`

## Requirements
- R1: At slot base + 0x0, each group has a membership mask in bits [NUM_CH-1:0]. A write stores those bits and ignores the upper bits. A read returns the stored mask with the upper bits at 0.
- R2: At slot base + 0x4, each group has a counter-reset flag in bit 0. It reads back in bit 0, with all other bits at 0.
- R3: A write to slot base + 0x8 with bit 0 = 1 drives `apply_pulse` high on exactly the member channels. The mask used is the one stored before that write. The pulse is high for the single cycle after the write edge. A write there with bit 0 = 0 produces no pulse.
- R4: `clear_pulse` rises on the same channels and in the same cycle as `apply_pulse`, but only when the started group's counter-reset flag is 1. Otherwise it stays 0.
- R5: The launch register at + 0x8 always reads 0. Writing it changes neither the mask nor the flag.
- R6: Pulses from all groups started in a cycle are merged per channel. A channel that belongs to several groups gets at most one pulse of each kind per cycle. Members of groups that were not started get no pulse.
- R7: Writes have no effect, and reads return 0, at three kinds of address: offset + 0xC of any slot, slots numbered NUM_GROUPS and above, and any address with a nonzero bit at or above bit 8. Address bits [1:0] are ignored.
- R8: After reset, every mask and every flag is 0, and both pulse outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Write strobe, sampled on the rising edge |
| reg_addr | input | ADDR_W | Byte address for both write and read |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| apply_pulse | output | NUM_CH | One-cycle per-channel "take staged settings" pulse |
| clear_pulse | output | NUM_CH | One-cycle per-channel "restart period counter" pulse |

## Verification
A mask or flag write is visible on `reg_rdata` as soon as the write edge has passed. The bench therefore reads each register back at the falling edge that follows the write, with the strobe already dropped. A launch write moves its pulses to the outputs exactly one edge later. The bench samples both pulse vectors at the falling edge right after that write edge, then samples them once more a cycle later to confirm they are back at 0. The sweep covers every group slot with all 256 masks and alternating reset flags. The expected vectors come straight from the mask and flag that the bench itself wrote.

// File: rtl/gsc_pkg.sv
package gsc_pkg;
  // word offset inside a 16-byte group slot
  typedef enum logic [1:0] {
    OFS_MASK  = 2'd0,
    OFS_RESET = 2'd1,
    OFS_LAUNCH = 2'd2,
    OFS_SPARE = 2'd3
  } gsc_ofs_e;

  localparam int SLOT_BITS  = 4;   // 16 slots in the map
  localparam int SLOT_SPAN_LSB = 4; // 0x10 stride
  localparam int WORD_LSB   = 2;
  localparam int MAP_BITS   = SLOT_BITS + SLOT_SPAN_LSB;
endpackage

// File: rtl/gsc_group_slot.sv
module gsc_group_slot #(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_mask,
  input  logic              wr_reset,
  input  logic              wr_launch,
  input  logic [DATA_W-1:0] wdata,
  output logic [NUM_CH-1:0] mask_q,
  output logic              reset_q,
  output logic              launch_hit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      reset_q <= 1'b0;
    end else begin
      if (wr_mask)  mask_q  <= wdata[NUM_CH-1:0];
      if (wr_reset) reset_q <= wdata[0];
    end
  end

  // launch is a strobe only; nothing is stored
  assign launch_hit = wr_launch & wdata[0];

  p_mask_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mask |=> $stable(mask_q));
  p_flag_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_reset |=> $stable(reset_q));
  p_launch_no_state_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_launch |=> ($stable(mask_q) && $stable(reset_q)));
endmodule

// File: rtl/gsc_pulse_merge.sv
module gsc_pulse_merge #(
  parameter int NUM_GROUPS = 4,
  parameter int NUM_CH     = 8
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NUM_GROUPS-1:0]              hit,
  input  logic [NUM_GROUPS-1:0]              reset_en,
  input  logic [NUM_GROUPS-1:0][NUM_CH-1:0]  masks,
  output logic [NUM_CH-1:0]                  apply_q,
  output logic [NUM_CH-1:0]                  clear_q
);
  logic [NUM_CH-1:0] apply_d, clear_d;

  always_comb begin
    apply_d = '0;
    clear_d = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (hit[g]) begin
        apply_d = apply_d | masks[g];
        if (reset_en[g]) clear_d = clear_d | masks[g];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      apply_q <= '0;
      clear_q <= '0;
    end else begin
      apply_q <= apply_d;
      clear_q <= clear_d;
    end
  end

  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit == '0) |=> (apply_q == '0 && clear_q == '0));
  p_clear_inside_apply_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((clear_q & ~apply_q) == '0));
  p_unflagged_no_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((hit & reset_en) == '0) |=> (clear_q == '0));
endmodule

// File: rtl/gsc_read_mux.sv
module gsc_read_mux
  import gsc_pkg::*;
#(
  parameter int NUM_GROUPS = 4,
  parameter int NUM_CH     = 8,
  parameter int DATA_W     = 32
) (
  input  logic                              slot_ok,
  input  logic [SLOT_BITS-1:0]              slot,
  input  gsc_ofs_e                          ofs,
  input  logic [NUM_GROUPS-1:0][NUM_CH-1:0] masks,
  input  logic [NUM_GROUPS-1:0]             reset_en,
  output logic [DATA_W-1:0]                 rdata
);
  always_comb begin
    rdata = '0;
    if (slot_ok) begin
      for (int g = 0; g < NUM_GROUPS; g++) begin
        if (slot == SLOT_BITS'(g)) begin
          unique case (ofs)
            OFS_MASK:  rdata = DATA_W'(masks[g]);
            OFS_RESET: rdata = DATA_W'(reset_en[g]);
            default:   rdata = '0;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/grp_sync_start.sv
module grp_sync_start
  import gsc_pkg::*;
#(
  parameter int NUM_GROUPS = 4,
  parameter int NUM_CH     = 8,
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [NUM_CH-1:0] apply_pulse,
  output logic [NUM_CH-1:0] clear_pulse
);
  localparam int HI_BITS = ADDR_W - MAP_BITS;

  logic                              in_map;
  logic [SLOT_BITS-1:0]              slot;
  gsc_ofs_e                          ofs;
  logic                              slot_ok;
  logic [NUM_GROUPS-1:0][NUM_CH-1:0] masks;
  logic [NUM_GROUPS-1:0]             reset_en;
  logic [NUM_GROUPS-1:0]             hit;

  assign in_map  = (reg_addr[ADDR_W-1:MAP_BITS] == HI_BITS'(0));
  assign slot    = reg_addr[MAP_BITS-1:SLOT_SPAN_LSB];
  assign ofs     = gsc_ofs_e'(reg_addr[SLOT_SPAN_LSB-1:WORD_LSB]);
  assign slot_ok = in_map && ({1'b0, slot} < (SLOT_BITS+1)'(NUM_GROUPS));

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_slot
    logic sel_here;
    assign sel_here = reg_wr_en && slot_ok && (slot == SLOT_BITS'(g));

    gsc_group_slot #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_mask    (sel_here && ofs == OFS_MASK),
      .wr_reset   (sel_here && ofs == OFS_RESET),
      .wr_launch  (sel_here && ofs == OFS_LAUNCH),
      .wdata      (reg_wdata),
      .mask_q     (masks[g]),
      .reset_q    (reset_en[g]),
      .launch_hit (hit[g])
    );
  end

  gsc_pulse_merge #(.NUM_GROUPS(NUM_GROUPS), .NUM_CH(NUM_CH)) u_merge (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit      (hit),
    .reset_en (reset_en),
    .masks    (masks),
    .apply_q  (apply_pulse),
    .clear_q  (clear_pulse)
  );

  gsc_read_mux #(.NUM_GROUPS(NUM_GROUPS), .NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_rd (
    .slot_ok  (slot_ok),
    .slot     (slot),
    .ofs      (ofs),
    .masks    (masks),
    .reset_en (reset_en),
    .rdata    (reg_rdata)
  );

  p_dead_read_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!slot_ok || ofs == OFS_SPARE) |-> (reg_rdata == '0));
  p_launch_reads_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ofs == OFS_LAUNCH) |-> (reg_rdata == '0));
  p_dead_write_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && !slot_ok) |=> (apply_pulse == '0));
endmodule

// File: tb/tb_grp_sync_start.sv
`timescale 1ns/1ps
module tb_grp_sync_start;
  localparam int NG = 4;
  localparam int NC = 8;
  localparam int AW = 12;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr_en = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic [NC-1:0] apply_pulse, clear_pulse;

  int total = 0;
  int fails = 0;

  always #2 clk = ~clk;

  grp_sync_start #(.NUM_GROUPS(NG), .NUM_CH(NC), .ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .apply_pulse(apply_pulse), .clear_pulse(clear_pulse));

  function automatic logic [AW-1:0] ad(int g, int k);
    return AW'(g * 16 + k * 4);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // returns at the falling edge after the write edge
  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [AW-1:0] a, logic [31:0] exp);
    reg_addr = a;
    #0.5;
    chk(req, reg_rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 apply", 32'(apply_pulse), 0);
    chk("R8 clear", 32'(clear_pulse), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int g = 0; g < NG; g++) begin
      rd_chk("R8 mask", ad(g, 0), 0);
      rd_chk("R8 flag", ad(g, 1), 0);
    end

    // sweep: every group, every mask
    for (int g = 0; g < NG; g++) begin
      for (int m = 0; m < 256; m++) begin
        logic [31:0] ce;
        ce = 32'((m >> g) & 1);
        wr(ad(g, 0), 32'hFFFF_FF00 | 32'(m));
        rd_chk("R1 mask readback", ad(g, 0), 32'(m));
        wr(ad(g, 1), 32'hA5A5_A5A4 | ce);
        rd_chk("R2 flag readback", ad(g, 1), ce);
        wr(ad(g, 2), 32'h1);
        chk("R3 apply", 32'(apply_pulse), 32'(m));
        chk("R4 clear", 32'(clear_pulse), ce[0] ? 32'(m) : 32'h0);
        rd_chk("R5 launch reads 0", ad(g, 2), 0);
        rd_chk("R5 mask kept", ad(g, 0), 32'(m));
        @(negedge clk);
        chk("R3 single cycle apply", 32'(apply_pulse), 0);
        chk("R4 single cycle clear", 32'(clear_pulse), 0);
      end
      wr(ad(g, 0), 0);
      wr(ad(g, 1), 0);
    end

    // R3 launch with bit0 = 0
    wr(ad(1, 0), 32'h5A);
    wr(ad(1, 1), 32'h1);
    wr(ad(1, 2), 32'hFFFF_FFFE);
    chk("R3 bit0=0 no apply", 32'(apply_pulse), 0);
    chk("R4 bit0=0 no clear", 32'(clear_pulse), 0);

    // R6 overlapping groups
    wr(ad(0, 0), 32'h0F);
    wr(ad(1, 0), 32'h3C);
    wr(ad(1, 1), 32'h0);
    wr(ad(0, 2), 32'h1);
    chk("R6 only started group", 32'(apply_pulse), 32'h0F);
    @(negedge clk);
    chk("R6 shared channel once", 32'(apply_pulse), 0);
    wr(ad(1, 2), 32'h1);
    chk("R6 second group", 32'(apply_pulse), 32'h3C);
    chk("R6 second group no clear", 32'(clear_pulse), 0);

    // R7 dead addresses
    wr(ad(0, 3), 32'hFFFF_FFFF);
    rd_chk("R7 spare reads 0", ad(0, 3), 0);
    rd_chk("R7 spare no effect", ad(0, 0), 32'h0F);
    wr(ad(NG, 0), 32'hFF);
    rd_chk("R7 unbuilt slot reads 0", ad(NG, 0), 0);
    wr(ad(NG, 2), 32'h1);
    chk("R7 unbuilt launch quiet", 32'(apply_pulse), 0);
    wr(AW'(12'h100), 32'hAA);
    rd_chk("R7 high address reads 0", AW'(12'h100), 0);
    rd_chk("R7 high address no alias", ad(0, 0), 32'h0F);
    wr(ad(2, 0) | AW'(3), 32'h81);
    rd_chk("R7 low addr bits ignored", ad(2, 0), 32'h81);

    // R8 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    rd_chk("R8 mask after reset", ad(0, 0), 0);
    chk("R8 apply after reset", 32'(apply_pulse), 0);
    @(negedge clk);
    rst_n = 1'b1;

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule